// File: doc/BRIEF.md
# Register Rename Status Table

This block records, for every architectural register of an out-of-order core, whether the register file already holds that register's latest value. If the value is still being computed, the entry holds the tag of the reservation station that will produce it. An entry of zero means "value available". Station tags therefore start at 1. Register 0 is hard-wired as available.

Each cycle the issue stage reads two entries combinationally, one for each source operand of the instruction being issued. On the same cycle the issue stage may claim the instruction's destination register by writing the chosen station's tag into it.

The writeback path presents the committing station's tag together with its destination register. The entry is cleared only if it still holds that exact tag. This way, a register that a younger instruction has already reclaimed stays pending. Because the destination register comes with the writeback, the table never has to search its entries by tag.

Top module: `rename_status_table`

## Requirements
- R1: While reset is asserted, and after it is released, every entry reads as zero until a write changes it.
- R2: The two read ports are independent. Each returns the entry addressed by its own index, and both return the same value when given the same index.
- R3: An issue write with a nonzero destination register stores the supplied tag in that entry. The new value is visible on the read ports from the next cycle on.
- R4: An issue write that targets register 0 has no effect, and register 0 always reads as zero.
- R5: A writeback whose tag equals the addressed entry's current value sets that entry to zero from the next cycle on.
- R6: A writeback whose tag differs from the addressed entry's current value leaves the entry unchanged.
- R7: When an issue write to a nonzero register and a writeback address the same register in the same cycle, the issue write wins. The entry holds the new tag in the next cycle.
- R8: A read in the cycle of a write returns the entry's value from before that write.
- R9: An issue write and a writeback to different registers both take effect in the same cycle. Entries addressed by neither keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_idx | input | REG_W | Source operand A register index |
| rd_a_tag | output | TAG_W | Entry for rd_a_idx (0 = available) |
| rd_b_idx | input | REG_W | Source operand B register index |
| rd_b_tag | output | TAG_W | Entry for rd_b_idx (0 = available) |
| iss_en | input | 1 | Claim a destination register this cycle |
| iss_reg | input | REG_W | Destination register being claimed |
| iss_tag | input | TAG_W | Reservation station tag, 1..NUM_STATIONS |
| wb_en | input | 1 | Writeback of a committing result this cycle |
| wb_reg | input | REG_W | Destination register of the committing result |
| wb_tag | input | TAG_W | Tag of the committing reservation station |

## Verification
Reads are combinational, so a read result belongs to the cycle in which its index is presented. It is checked shortly after the inputs are driven and before the next rising edge, against the bench's model state from before that edge.

Both kinds of write take effect at the next rising edge. The bench applies them to its model at that same edge. The first read checked after that edge must therefore show the new value, which is exactly one cycle after the write was presented.

Full sweeps over all registers on both ports follow each directed phase. A long run of mixed random traffic then exercises collisions and stale writebacks in every combination.

// File: rtl/rename_status_table.sv
module rename_status_table #(
  parameter int NUM_REGS     = 32,
  parameter int NUM_STATIONS = 7,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int TAG_W = $clog2(NUM_STATIONS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] rd_a_idx,
  output logic [TAG_W-1:0] rd_a_tag,
  input  logic [REG_W-1:0] rd_b_idx,
  output logic [TAG_W-1:0] rd_b_tag,
  input  logic             iss_en,
  input  logic [REG_W-1:0] iss_reg,
  input  logic [TAG_W-1:0] iss_tag,
  input  logic             wb_en,
  input  logic [REG_W-1:0] wb_reg,
  input  logic [TAG_W-1:0] wb_tag
);

  logic [TAG_W-1:0] pend [NUM_REGS];

  logic claim, release_ok;

  assign claim      = iss_en && (iss_reg != '0);
  assign release_ok = wb_en && (pend[wb_reg] == wb_tag) &&
                      !(claim && (iss_reg == wb_reg));

  assign rd_a_tag = pend[rd_a_idx];
  assign rd_b_tag = pend[rd_b_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) pend[i] <= '0;
    end else begin
      if (release_ok) pend[wb_reg]  <= '0;
      if (claim)      pend[iss_reg] <= iss_tag;
    end
  end

endmodule

// File: rtl/rename_status_table_chk.sv
module rename_status_table_chk #(
  parameter int REG_W = 5,
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] rd_a_idx,
  input logic [TAG_W-1:0] rd_a_tag,
  input logic [REG_W-1:0] rd_b_idx,
  input logic [TAG_W-1:0] rd_b_tag,
  input logic             iss_en,
  input logic [REG_W-1:0] iss_reg,
  input logic [TAG_W-1:0] iss_tag,
  input logic             wb_en,
  input logic [REG_W-1:0] wb_reg,
  input logic [TAG_W-1:0] wb_tag
);

  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == rd_b_idx) |-> (rd_a_tag == rd_b_tag)); // R2

  AST_ISSUE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_en && iss_reg != '0) |=>
      (rd_a_idx != $past(iss_reg) || rd_a_tag == $past(iss_tag))); // R3

  AST_REG0_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == '0) |-> (rd_a_tag == '0)); // R4

  AST_WB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && rd_a_idx == wb_reg && rd_a_tag == wb_tag &&
     !(iss_en && iss_reg == wb_reg)) |=>
      (rd_a_idx != $past(wb_reg) || rd_a_tag == '0)); // R5

  AST_WB_STALE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && rd_a_idx == wb_reg && rd_a_tag != wb_tag &&
     !(iss_en && iss_reg == wb_reg)) |=>
      (rd_a_idx != $past(wb_reg) || rd_a_tag == $past(rd_a_tag))); // R6

  AST_ISSUE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_en && wb_en && iss_reg == wb_reg && iss_reg != '0) |=>
      (rd_b_idx != $past(iss_reg) || rd_b_tag == $past(iss_tag))); // R7

endmodule

bind rename_status_table rename_status_table_chk #(.REG_W(REG_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/rename_status_table_tb.sv
module rename_status_table_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 32;
  localparam int NS = 7;
  localparam int RW = $clog2(NR);
  localparam int TW = $clog2(NS + 1);

  logic clk = 0, rst_n = 0;
  logic [RW-1:0] rd_a_idx = '0, rd_b_idx = '0, iss_reg = '0, wb_reg = '0;
  logic [TW-1:0] rd_a_tag, rd_b_tag, iss_tag = '0, wb_tag = '0;
  logic iss_en = 0, wb_en = 0;

  int model [NR];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_status_table #(.NUM_REGS(NR), .NUM_STATIONS(NS)) u_dut (.*);

  task automatic check(input string req, input int act, input int exp, input int reg_i);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s reg %0d: got %0d expected %0d", req, reg_i, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check pre-edge reads, update model at the edge.
  task automatic step(input bit ie, input int ir, input int it,
                      input bit we, input int wr, input int wt,
                      input int ra, input int rb, input string req);
    bit ok_iss, ok_wb;
    @(negedge clk);
    iss_en = ie; iss_reg = RW'(ir); iss_tag = TW'(it);
    wb_en = we;  wb_reg = RW'(wr);  wb_tag = TW'(wt);
    rd_a_idx = RW'(ra); rd_b_idx = RW'(rb);
    #1;
    check(req, int'(rd_a_tag), model[ra], ra);
    check(req, int'(rd_b_tag), model[rb], rb);
    @(posedge clk);
    ok_iss = ie && ir != 0;
    ok_wb  = we && model[wr] == wt && !(ok_iss && ir == wr);
    if (ok_wb)  model[wr] = 0;
    if (ok_iss) model[ir] = it;
  endtask

  task automatic sweep(input string req);
    for (int r = 0; r < NR; r++) step(0, 0, 0, 0, 0, 0, r, NR - 1 - r, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; iss_en = 0; wb_en = 0;
    @(posedge clk); @(posedge clk);
    for (int r = 0; r < NR; r++) model[r] = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) model[r] = 0;
    @(negedge clk);
    #1;
    check("R1", int'(rd_a_tag), 0, 0);
    do_reset();
    sweep("R1");

    // Claim every register (register 0 claim must be dropped); reads see pre-write state.
    for (int r = 0; r < NR; r++) step(1, r, (r % NS) + 1, 0, 0, 0, r, (r + 1) % NR, "R3_R8");
    sweep("R3_R4");

    // Stale writebacks on even registers: tag differs from the entry.
    for (int r = 2; r < NR; r += 2) step(0, 0, 0, 1, r, (model[r] % NS) + 1, r, r, "R6");
    sweep("R6");

    // Matching writebacks on odd registers.
    for (int r = 1; r < NR; r += 2) step(0, 0, 0, 1, r, model[r], r, r, "R5_R8");
    sweep("R5");

    // Collision: issue and matching writeback to the same register.
    for (int r = 2; r < 12; r += 2) step(1, r, ((model[r] + 2) % NS) + 1, 1, r, model[r], r, 0, "R7");
    sweep("R7");

    // Issue and writeback to different registers in the same cycle.
    for (int r = 12; r < NR; r += 2) step(1, r - 11, 5, 1, r, model[r], r, r - 11, "R9");
    sweep("R9");

    // Mixed random traffic.
    for (int i = 0; i < 4000; i++) begin
      int ir = $urandom_range(NR - 1);
      int wr = ($urandom_range(3) == 0) ? ir : $urandom_range(NR - 1);
      int wt = ($urandom_range(2) != 0) ? model[wr] : $urandom_range(NS);
      step($urandom_range(1), ir, $urandom_range(NS) + 1 > NS ? NS : $urandom_range(NS - 1) + 1,
           $urandom_range(1), wr, wt, $urandom_range(NR - 1), $urandom_range(NR - 1), "R2_R9");
    end
    sweep("R2");

    do_reset();
    sweep("R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule